// File: doc/BRIEF.md
# Indivisible Test-and-Set Bus Master

This block is a bus master sequencer. It performs one atomic test-and-set on a single byte over an asynchronous 16-bit bus that uses strobes. A one-cycle `start` pulse supplies a byte address and a function code. The master then reads the addressed byte, forces its top bit to one, and writes the result back to the same location.

The address strobe stays low from the start of the read strobe to the end of the write strobe. Any other master therefore sees the read and the write as a single bus cycle that cannot be split. Each half waits as long as the slave takes to acknowledge. The acknowledge and bus-error inputs each pass through a two-flop synchronizer.

When the cycle completes, `done` pulses for one clock and the zero and negative flags describe the byte as it was read. If a bus error arrives, the cycle is abandoned without a write and `err` pulses instead. The address and data pads are not modelled as tri-state pins. Separate output enables mark when the master drives them.

Top module: `tas_bus_master`

## Requirements
- R1: After reset, all three strobes are high, `bus_rw` is 1 (read), both output enables are 0, and `busy`, `done` and `err` are 0.
- R2: Byte lane is selected by `byte_addr[0]`: 0 uses `uds_n` with data on bits 15:8, and 1 uses `lds_n` with data on bits 7:0. The other strobe is never asserted, and the two data strobes are never low together.
- R3: Before the address strobe falls, the address bus is enabled with `bus_rw` at 1. While the read strobe is low, `bus_addr` equals `byte_addr[23:1]` and `bus_fc` equals `fc_in`.
- R4: A data strobe stays low until the synchronized acknowledge arrives, for any number of wait states. The read byte is taken from the selected lane when that acknowledge arrives.
- R5: `as_n` falls exactly once per cycle and stays low through both halves. `bus_addr` is stable while it is low. The data strobe goes high between the halves, and `bus_rw` falls only after the slave has released its acknowledge.
- R6: During the write half, `bus_rw` is 0 and the selected lane carries the read byte with bit 7 set.
- R7: At termination, one cycle has all strobes high while `bus_rw` is still 0 and the buses are still enabled. In the next cycle both enables are 0, `bus_rw` is 1, and `done` is high for exactly one cycle.
- R8: On completion, `flag_z` is 1 exactly when the read byte was 0x00, and `flag_n` equals bit 7 of the read byte. Both flags keep their value until the next completion.
- R9: A bus error during either half returns all strobes high in the cycle where `err` pulses high. It performs no write (or no further write), gives no `done`, and leaves the flags unchanged.
- R10: A `start` pulse while `busy` is 1 is ignored. No second cycle runs, and the address of the running cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one test-and-set cycle |
| byte_addr | input | 24 | Byte address; bit 0 picks the lane |
| fc_in | input | 3 | Function code for the cycle |
| bus_addr | output | 23 | Word address on the bus |
| bus_fc | output | 3 | Function code on the bus |
| bus_rw | output | 1 | 1 = read, 0 = write |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| addr_oe | output | 1 | Drive enable for address and function code |
| data_oe | output | 1 | Drive enable for write data |
| data_out | output | 16 | Write data (byte copied on both lanes) |
| data_in | input | 16 | Read data from the slave |
| dtack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| berr_n | input | 1 | Bus error, active low, asynchronous |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle pulse on completion |
| err | output | 1 | One-cycle pulse on abort |
| flag_z | output | 1 | Original byte was zero |
| flag_n | output | 1 | Bit 7 of original byte |

## Verification
The hardest situation to reach is the gap between the halves. There the address strobe must stay low while the data strobe is high. The write must also wait until a slow, synchronized acknowledge has actually fallen away. The bench slave releases its acknowledge only after it sees the strobe rise, and it uses a different number of wait states for each half. A monitor then confirms that the read/write line never falls while the acknowledge is still low. The same slave can answer with a bus error in either half, which reaches the abort path before and after the write strobe has started.

// File: rtl/tas_bus_master.sv
module tas_bus_master #(
  parameter int AW  = 23,
  parameter int FCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW:0]    byte_addr,
  input  logic [FCW-1:0] fc_in,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic           bus_rw,
  output logic           as_n,
  output logic           uds_n,
  output logic           lds_n,
  output logic           addr_oe,
  output logic           data_oe,
  output logic [15:0]    data_out,
  input  logic [15:0]    data_in,
  input  logic           dtack_n,
  input  logic           berr_n,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           flag_z,
  output logic           flag_n
);

  typedef enum logic [2:0] {
    S_IDLE, S_RADDR, S_RSTRB, S_RGAP, S_WSETUP, S_WSTRB, S_END
  } st_t;

  st_t            st;
  logic [1:0]     ack_sy, berr_sy;
  logic [AW:0]    addr_q;
  logic [FCW-1:0] fc_q;
  logic [7:0]     rd_q;

  wire ack_s   = ack_sy[1];
  wire berr_s  = berr_sy[1];
  wire lane_lo = addr_q[0];
  wire ds_on   = (st == S_RSTRB) || (st == S_WSTRB);
  wire as_on   = (st == S_RSTRB) || (st == S_RGAP) || (st == S_WSETUP) || (st == S_WSTRB);
  wire wr_ph   = (st == S_WSETUP) || (st == S_WSTRB) || (st == S_END);
  wire [7:0] lane_byte = lane_lo ? data_in[7:0] : data_in[15:8];
  wire [7:0] wr_byte   = rd_q | 8'h80;

  assign busy     = (st != S_IDLE);
  assign as_n     = ~as_on;
  assign uds_n    = ~(ds_on & ~lane_lo);
  assign lds_n    = ~(ds_on & lane_lo);
  assign bus_rw   = ~wr_ph;
  assign addr_oe  = busy;
  assign data_oe  = wr_ph;
  assign bus_addr = addr_oe ? addr_q[AW:1] : '0;
  assign bus_fc   = addr_oe ? fc_q : '0;
  assign data_out = data_oe ? {wr_byte, wr_byte} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sy  <= '0;
      berr_sy <= '0;
    end else begin
      ack_sy  <= {ack_sy[0], ~dtack_n};
      berr_sy <= {berr_sy[0], ~berr_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      fc_q   <= '0;
      rd_q   <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (as_on && berr_s) begin
        st  <= S_IDLE;
        err <= 1'b1;
      end else begin
        case (st)
          S_IDLE:
            if (start) begin
              addr_q <= byte_addr;
              fc_q   <= fc_in;
              st     <= S_RADDR;
            end
          S_RADDR:
            if (!ack_s && !berr_s) st <= S_RSTRB;
          S_RSTRB:
            if (ack_s) begin
              rd_q <= lane_byte;
              st   <= S_RGAP;
            end
          S_RGAP:
            if (!ack_s) st <= S_WSETUP;
          S_WSETUP:
            st <= S_WSTRB;
          S_WSTRB:
            if (ack_s) st <= S_END;
          S_END: begin
            st     <= S_IDLE;
            done   <= 1'b1;
            flag_z <= (rd_q == 8'h00);
            flag_n <= rd_q[7];
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !(!uds_n && !lds_n));
  a_r2_ds_under_as: assert property (@(posedge clk) disable iff (!rst_n)
    (!uds_n || !lds_n) |-> !as_n);
  a_r3_setup_before_as: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) |-> $past(addr_oe) && $past(bus_rw) && bus_rw);
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && $past(!as_n)) |-> $stable(bus_addr));
  a_r5_write_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rw) |-> !as_n && $past(!as_n) && uds_n && lds_n);
  a_r6_write_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !bus_rw) |-> data_out[15] && data_out[7]);
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!bus_rw) && $past(as_n) && bus_rw && !addr_oe);
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> as_n && uds_n && lds_n && !done);

endmodule

// File: tb/tb_tas_bus_master.sv
module tb_tas_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] byte_addr = '0;
  logic [2:0]  fc_in = '0;
  logic [22:0] bus_addr;
  logic [2:0]  bus_fc;
  logic        bus_rw, as_n, uds_n, lds_n, addr_oe, data_oe;
  logic [15:0] data_out;
  logic [15:0] data_in;
  logic        dtack_n, berr_n;
  logic        busy, done, err, flag_z, flag_n;

  always #2.5 clk = ~clk;

  tas_bus_master dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_addr(byte_addr), .fc_in(fc_in),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rw(bus_rw), .as_n(as_n),
    .uds_n(uds_n), .lds_n(lds_n), .addr_oe(addr_oe), .data_oe(data_oe),
    .data_out(data_out), .data_in(data_in), .dtack_n(dtack_n), .berr_n(berr_n),
    .busy(busy), .done(done), .err(err), .flag_z(flag_z), .flag_n(flag_n)
  );

  int checks = 0;
  int errors = 0;

  // slave configuration
  logic [7:0] cfg_rd = '0;
  int         cfg_rwait = 0, cfg_wwait = 0, cfg_berr = 0;
  int         cnt;
  wire        ds_act = !uds_n || !lds_n;

  always @(negedge clk) begin
    if (!rst_n) begin
      dtack_n <= 1'b1; berr_n <= 1'b1; cnt <= 0; data_in <= '0;
    end else if (ds_act && !as_n) begin
      cnt <= cnt + 1;
      if (cnt >= (bus_rw ? cfg_rwait : cfg_wwait)) begin
        if ((cfg_berr == 1 && bus_rw) || (cfg_berr == 2 && !bus_rw)) berr_n <= 1'b0;
        else dtack_n <= 1'b0;
      end
      data_in <= !uds_n ? {cfg_rd, ~cfg_rd} : {~cfg_rd, cfg_rd};
    end else begin
      cnt <= 0; dtack_n <= 1'b1; berr_n <= 1'b1;
    end
  end

  // bus monitor
  logic       mon_clr = 1'b0;
  logic       prev_as = 1'b1, prev_rw = 1'b1;
  int         n_as_fall, n_rd_u, n_rd_l, n_wr_u, n_wr_l, n_gap, n_end, n_early;
  logic [7:0] wr_val;
  logic [22:0] got_addr;
  logic [2:0]  got_fc;

  always @(negedge clk) begin
    prev_as <= as_n;
    prev_rw <= bus_rw;
    if (mon_clr) begin
      n_as_fall <= 0; n_rd_u <= 0; n_rd_l <= 0; n_wr_u <= 0; n_wr_l <= 0;
      n_gap <= 0; n_end <= 0; n_early <= 0; wr_val <= '0; got_addr <= '0; got_fc <= '0;
    end else begin
      if (prev_as && !as_n) n_as_fall <= n_as_fall + 1;
      if (prev_rw && !bus_rw && !dtack_n) n_early <= n_early + 1;
      if (!as_n && uds_n && lds_n && bus_rw) n_gap <= n_gap + 1;
      if (as_n && !bus_rw && data_oe && addr_oe) n_end <= n_end + 1;
      if (!uds_n) begin
        if (bus_rw) begin n_rd_u <= n_rd_u + 1; got_addr <= bus_addr; got_fc <= bus_fc; end
        else begin n_wr_u <= n_wr_u + 1; wr_val <= data_out[15:8]; end
      end
      if (!lds_n) begin
        if (bus_rw) begin n_rd_l <= n_rd_l + 1; got_addr <= bus_addr; got_fc <= bus_fc; end
        else begin n_wr_l <= n_wr_l + 1; wr_val <= data_out[7:0]; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {addr[23:0], read byte, read waits, write waits, fc}
  localparam logic [42:0] VEC [6] = '{
    {24'h000100, 8'h00, 4'd0, 4'd0, 3'd5},
    {24'h7FFFFF, 8'h80, 4'd2, 4'd1, 3'd1},
    {24'hABCDE2, 8'h7F, 4'd1, 4'd3, 3'd6},
    {24'h123457, 8'hFF, 4'd5, 4'd0, 3'd2},
    {24'hFFFFFE, 8'h35, 4'd0, 4'd4, 3'd7},
    {24'h000001, 8'h01, 4'd3, 4'd2, 3'd0}
  };

  bit got_done, got_err, quiet_ok, idle_ok;

  task automatic run_cycle(input logic [42:0] v, input int berr_mode, input bit extra_start);
    cfg_rd = v[18:11]; cfg_rwait = int'(v[10:7]); cfg_wwait = int'(v[6:3]); cfg_berr = berr_mode;
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
    byte_addr = v[42:19]; fc_in = v[2:0]; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (extra_start) begin
      repeat (3) @(posedge clk);
      #1 byte_addr = ~v[42:19]; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    got_done = 0; got_err = 0; quiet_ok = 0; idle_ok = 0;
    for (int k = 0; k < 300 && !got_done && !got_err; k++) begin
      @(negedge clk);
      if (done) begin got_done = 1; idle_ok = !addr_oe && !data_oe && bus_rw && !err; end
      if (err)  begin got_err = 1; quiet_ok = as_n && uds_n && lds_n; end
    end
    @(negedge clk);
    if (got_done) chk(!done, "R7 done single-cycle", 32'(done), 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic check_ok(input logic [42:0] v);
    logic [7:0] rd = v[18:11];
    bit lo = v[19];
    int sel_rd = lo ? n_rd_l : n_rd_u;
    int sel_wr = lo ? n_wr_l : n_wr_u;
    int other  = lo ? (n_rd_u + n_wr_u) : (n_rd_l + n_wr_l);
    chk(got_done, "R7 done seen", 32'(got_done), 1);
    chk(idle_ok, "R7 buses released with done", 32'(idle_ok), 1);
    chk(n_end == 1, "R7 termination cycle", 32'(n_end), 1);
    chk(got_addr == v[42:20], "R3 word address", 32'(got_addr), 32'(v[42:20]));
    chk(got_fc == v[2:0], "R3 function code", 32'(got_fc), 32'(v[2:0]));
    chk(sel_rd > 0 && sel_wr > 0 && other == 0, "R2 lane select", 32'(other), 0);
    chk(sel_rd >= int'(v[10:7]) + 1, "R4 read wait states", 32'(sel_rd), 32'(int'(v[10:7]) + 1));
    chk(sel_wr >= int'(v[6:3]) + 1, "R4 write wait states", 32'(sel_wr), 32'(int'(v[6:3]) + 1));
    chk(wr_val == (rd | 8'h80), "R6 written byte", 32'(wr_val), 32'(rd | 8'h80));
    chk(n_as_fall == 1, "R5 single address strobe", 32'(n_as_fall), 1);
    chk(n_gap > 0 && n_early == 0, "R5 gap between halves", 32'(n_early), 0);
    chk(flag_z == (rd == 8'h00), "R8 zero flag", 32'(flag_z), 32'(rd == 8'h00));
    chk(flag_n == rd[7], "R8 negative flag", 32'(flag_n), 32'(rd[7]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic fz, fn;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(as_n && uds_n && lds_n, "R1 strobes idle", {29'd0, as_n, uds_n, lds_n}, 7);
    chk(bus_rw && !addr_oe && !data_oe, "R1 bus idle", {29'd0, bus_rw, addr_oe, data_oe}, 4);
    chk(!busy && !done && !err, "R1 status idle", {29'd0, busy, done, err}, 0);

    for (int i = 0; i < 6; i++) begin
      run_cycle(VEC[i], 0, 1'b0);
      check_ok(VEC[i]);
    end

    // R9 bus error in the read half
    fz = flag_z; fn = flag_n;
    run_cycle({24'h004444, 8'h00, 4'd1, 4'd0, 3'd3}, 1, 1'b0);
    chk(got_err && !got_done, "R9 read abort err", 32'(got_err), 1);
    chk(quiet_ok, "R9 strobes high at err", 32'(quiet_ok), 1);
    chk(n_wr_u + n_wr_l == 0, "R9 no write after read abort", 32'(n_wr_u + n_wr_l), 0);
    chk(flag_z == fz && flag_n == fn, "R9 flags kept", {30'd0, flag_z, flag_n}, {30'd0, fz, fn});

    // R9 bus error in the write half
    run_cycle({24'h004445, 8'h12, 4'd0, 4'd2, 3'd3}, 2, 1'b0);
    chk(got_err && !got_done, "R9 write abort err", 32'(got_err), 1);
    chk(quiet_ok, "R9 strobes high at write err", 32'(quiet_ok), 1);
    chk(flag_z == fz && flag_n == fn, "R9 flags kept after write abort", {30'd0, flag_z, flag_n}, {30'd0, fz, fn});

    // recovery after abort
    run_cycle(VEC[2], 0, 1'b0);
    check_ok(VEC[2]);

    // R10 start while busy is ignored
    run_cycle({24'h0A0A0A, 8'h00, 4'd6, 4'd3, 3'd4}, 0, 1'b1);
    chk(got_done, "R10 first cycle completes", 32'(got_done), 1);
    chk(n_as_fall == 1, "R10 no second cycle", 32'(n_as_fall), 1);
    chk(got_addr == 23'h050505, "R10 address kept", 32'(got_addr), 32'h050505);
    chk(!busy, "R10 idle afterwards", 32'(busy), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule